// File: doc/BRIEF.md
# DRAM Activate Throttling Controller

This block caps the number of row-activate commands each DIMM pair may issue inside a short throttling window. The cap is applied only when the pair has shown sustained traffic. Time is split into short windows of `WIN_CLKS` clocks. A whole number of short windows forms a long global window. For each pair, the block counts granted activates over the global window. At the end of the global window, the count decides whether that pair is throttled during the next global window. Because of this, a brief burst cannot cause throttling on its own; the long window acts as a low-pass filter.

While a pair is throttled and the throttle level N is non-zero, the pair may complete 4×N activates per short window. After that, its grant drops until the window ends. A level of 0 means no limit. A debug bit shortens the global window from `GLOBAL_NORMAL` to `GLOBAL_DEBUG` short windows. The level, the threshold and the debug bit are sampled only on the last clock of a short window. The scheduler asserts `act_req` for a pair and issues the activate only in a cycle where `act_grant` is high.

Each pair runs a three-state machine:
- PT_PASS: throttling is off.
- PT_ARMED: throttling is on and budget remains.
- PT_BLOCKED: throttling is on and the budget is used up.

Transitions:
- At a global-window end, every state goes to PT_ARMED if the pair's count including that cycle is at least the threshold, and to PT_PASS otherwise.
- PT_ARMED goes to PT_BLOCKED on the granted activate that brings the short-window count to 4×N, when N is non-zero and the cycle is not a short-window end.
- PT_BLOCKED goes back to PT_ARMED on a short-window end.

Top module: `act_throttle_ctrl`

## Requirements
- R1: During and after reset, all grants are 1, all throttling-active flags are 0 and all counters are 0. The level resets to 0, the threshold to all ones and the debug bit to 0.
- R2: With a level of 0, a pair keeps its grant in every cycle, even while its throttling-active flag is 1.
- R3: While throttled with level N>0, a pair's grant is 0 from the cycle after its short-window count reaches 4×N until the window ends. An activate is counted only when `act_req` and `act_grant` are both 1.
- R4: On the last clock of a short window (cycle index `WIN_CLKS`-1 counted from reset release), every short-window count clears. In the following cycle every grant is 1.
- R5: At the end of a global window, each pair's throttling-active flag becomes 1 if its global count, including that cycle's activate, is at least the threshold, and 0 otherwise. The global count then clears. The flag changes at no other time.
- R6: A pair whose throttling-active flag is 0 is never refused, however many activates it makes.
- R7: A global window is `GLOBAL_NORMAL` short windows when the sampled debug bit is 0, and `GLOBAL_DEBUG` short windows when it is 1.
- R8: Changes to the level, the threshold or the debug bit take effect only from the clock after the end of a short window.
- R9: The short-window and global counts saturate at all ones and do not wrap.
- R10: Every pair is counted, evaluated and throttled independently of the others.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| act_req | input | NUM_PAIRS | Activate wanted, one bit per DIMM pair |
| throttle_level | input | LEVEL_W | Level N; the budget is 4×N activates per short window, 0 means no limit |
| gwin_debug | input | 1 | 1 selects the short global window |
| glob_thresh | input | GCNT_W | Global activity count at which throttling turns on |
| act_grant | output | NUM_PAIRS | Activate allowed this cycle, per pair |
| thr_active | output | NUM_PAIRS | Throttling enabled for the pair in this global window |
| win_cnt | output | NUM_PAIRS×(LEVEL_W+2) | Granted activates in the current short window, per pair |
| glob_cnt | output | NUM_PAIRS×GCNT_W | Granted activates in the current global window, per pair |

## Verification
The hardest state to reach is a throttled pair that runs out of budget partway through a short window. Reaching it needs a full global window of heavy traffic first. The level register must also change while the window is open, and the change must wait for the boundary. The bench uses small window parameters. It keeps one pair busy for an entire global window so that the pair becomes throttled, and lets the other pair request only sparsely. It then changes the level, the threshold and the debug bit partway through windows. A cycle-level model of the requirements predicts the grant, the flag and both counts for every cycle.

// File: rtl/act_thr_pkg.sv
package act_thr_pkg;

    typedef enum logic [1:0] {
        PT_PASS    = 2'd0,
        PT_ARMED   = 2'd1,
        PT_BLOCKED = 2'd2
    } pair_state_e;

endpackage

// File: rtl/act_win_timer.sv
module act_win_timer #(
    parameter int WIN_CLKS      = 1344,
    parameter int GLOBAL_NORMAL = 16384,
    parameter int GLOBAL_DEBUG  = 4,
    parameter int LEVEL_W       = 8,
    parameter int GCNT_W        = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [LEVEL_W-1:0] lvl_in,
    input  logic               dbg_in,
    input  logic [GCNT_W-1:0]  thr_in,
    output logic               win_end,
    output logic               glob_end,
    output logic [LEVEL_W-1:0] lvl_q,
    output logic [GCNT_W-1:0]  thr_q
);
    localparam int WCYC_W = (WIN_CLKS > 2) ? $clog2(WIN_CLKS) : 1;
    localparam int GMAX   = (GLOBAL_NORMAL > GLOBAL_DEBUG) ? GLOBAL_NORMAL : GLOBAL_DEBUG;
    localparam int GW_W   = $clog2(GMAX) + 1;

    logic [WCYC_W-1:0] wcyc_q;
    logic [GW_W-1:0]   gwin_q;
    logic [GW_W-1:0]   glen_m1;
    logic              dbg_q;

    // Last short window of the global window, picked by the sampled mode.
    always_comb begin
        glen_m1  = dbg_q ? GW_W'(GLOBAL_DEBUG - 1) : GW_W'(GLOBAL_NORMAL - 1);
        win_end  = (wcyc_q == WCYC_W'(WIN_CLKS - 1));
        glob_end = win_end && (gwin_q >= glen_m1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wcyc_q <= '0;
            gwin_q <= '0;
            lvl_q  <= '0;
            thr_q  <= '1;
            dbg_q  <= 1'b0;
        end else if (win_end) begin
            wcyc_q <= '0;
            gwin_q <= glob_end ? '0 : gwin_q + 1'b1;
            lvl_q  <= lvl_in;
            thr_q  <= thr_in;
            dbg_q  <= dbg_in;
        end else begin
            wcyc_q <= wcyc_q + 1'b1;
        end
    end

endmodule

// File: rtl/act_pair_throttle.sv
module act_pair_throttle
    import act_thr_pkg::*;
#(
    parameter int LEVEL_W = 8,
    parameter int GCNT_W  = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req,
    input  logic                 win_end,
    input  logic                 glob_end,
    input  logic [LEVEL_W-1:0]   lvl,
    input  logic [GCNT_W-1:0]    thr,
    output logic                 grant,
    output logic                 active,
    output logic [LEVEL_W+1:0]   wcnt,
    output logic [GCNT_W-1:0]    gcnt
);
    localparam int CW = LEVEL_W + 2;

    pair_state_e     state_q, state_d;
    logic [CW-1:0]     budget;
    logic [CW-1:0]     wcnt_inc;
    logic [GCNT_W-1:0] gcnt_tot;
    logic              act;
    logic              hit;

    always_comb begin
        budget   = {lvl, 2'b00};
        act      = req && grant;
        wcnt_inc = (wcnt == '1) ? wcnt : wcnt + 1'b1;
        gcnt_tot = (act && (gcnt != '1)) ? gcnt + 1'b1 : gcnt;
        hit      = (gcnt_tot >= thr);
    end

    // Next-state decision.
    always_comb begin
        state_d = state_q;
        if (glob_end) begin
            state_d = hit ? PT_ARMED : PT_PASS;
        end else begin
            unique case (state_q)
                PT_PASS:    state_d = PT_PASS;
                PT_ARMED:   if (act && (lvl != '0) && (wcnt_inc >= budget) && !win_end)
                                state_d = PT_BLOCKED;
                PT_BLOCKED: if (win_end) state_d = PT_ARMED;
                default:    state_d = PT_PASS;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= PT_PASS;
        else        state_q <= state_d;
    end

    // Outputs.
    always_comb begin
        grant  = 1'b1;
        active = 1'b0;
        unique case (state_q)
            PT_PASS:    begin grant = 1'b1; active = 1'b0; end
            PT_ARMED:   begin grant = 1'b1; active = 1'b1; end
            PT_BLOCKED: begin grant = 1'b0; active = 1'b1; end
            default:    begin grant = 1'b1; active = 1'b0; end
        endcase
    end

    // Saturating activity counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wcnt <= '0;
            gcnt <= '0;
        end else begin
            if (win_end)  wcnt <= '0;
            else if (act) wcnt <= wcnt_inc;
            gcnt <= glob_end ? '0 : gcnt_tot;
        end
    end

endmodule

// File: rtl/act_throttle_ctrl.sv
module act_throttle_ctrl #(
    parameter int NUM_PAIRS     = 2,
    parameter int WIN_CLKS      = 1344,
    parameter int GLOBAL_NORMAL = 16384,
    parameter int GLOBAL_DEBUG  = 4,
    parameter int LEVEL_W       = 8,
    parameter int GCNT_W        = 32
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic [NUM_PAIRS-1:0]                 act_req,
    input  logic [LEVEL_W-1:0]                   throttle_level,
    input  logic                                 gwin_debug,
    input  logic [GCNT_W-1:0]                    glob_thresh,
    output logic [NUM_PAIRS-1:0]                 act_grant,
    output logic [NUM_PAIRS-1:0]                 thr_active,
    output logic [NUM_PAIRS-1:0][LEVEL_W+1:0]    win_cnt,
    output logic [NUM_PAIRS-1:0][GCNT_W-1:0]     glob_cnt
);
    logic               win_end;
    logic               glob_end;
    logic [LEVEL_W-1:0] lvl_q;
    logic [GCNT_W-1:0]  thr_q;

    act_win_timer #(
        .WIN_CLKS     (WIN_CLKS),
        .GLOBAL_NORMAL(GLOBAL_NORMAL),
        .GLOBAL_DEBUG (GLOBAL_DEBUG),
        .LEVEL_W      (LEVEL_W),
        .GCNT_W       (GCNT_W)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .lvl_in  (throttle_level),
        .dbg_in  (gwin_debug),
        .thr_in  (glob_thresh),
        .win_end (win_end),
        .glob_end(glob_end),
        .lvl_q   (lvl_q),
        .thr_q   (thr_q)
    );

    for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
        act_pair_throttle #(
            .LEVEL_W(LEVEL_W),
            .GCNT_W (GCNT_W)
        ) u_pair (
            .clk     (clk),
            .rst_n   (rst_n),
            .req     (act_req[p]),
            .win_end (win_end),
            .glob_end(glob_end),
            .lvl     (lvl_q),
            .thr     (thr_q),
            .grant   (act_grant[p]),
            .active  (thr_active[p]),
            .wcnt    (win_cnt[p]),
            .gcnt    (glob_cnt[p])
        );
    end

endmodule

// File: rtl/act_throttle_ctrl_chk.sv
module act_throttle_ctrl_chk #(
    parameter int NUM_PAIRS = 2,
    parameter int CW        = 10,
    parameter int GW        = 32
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          win_end,
    input logic                          glob_end,
    input logic [NUM_PAIRS-1:0]          act_req,
    input logic [NUM_PAIRS-1:0]          act_grant,
    input logic [NUM_PAIRS-1:0]          thr_active,
    input logic [NUM_PAIRS-1:0][CW-1:0]  win_cnt,
    input logic [NUM_PAIRS-1:0][GW-1:0]  glob_cnt
);
    for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_chk
        AST_GRANT_AFTER_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n) win_end |=> act_grant[p]); // R4
        AST_COUNT_CLEARED: assert property (@(posedge clk) disable iff (!rst_n) win_end |=> (win_cnt[p] == '0)); // R4
        AST_IDLE_NEVER_REFUSED: assert property (@(posedge clk) disable iff (!rst_n) !thr_active[p] |-> act_grant[p]); // R6
        AST_FLAG_ONLY_AT_GLOBAL: assert property (@(posedge clk) disable iff (!rst_n) !glob_end |=> $stable(thr_active[p])); // R5
        AST_NO_SILENT_COUNT: assert property (@(posedge clk) disable iff (!rst_n) (!win_end && !(act_req[p] && act_grant[p])) |=> $stable(win_cnt[p])); // R3
        AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) (!glob_end && (glob_cnt[p] == '1)) |=> (glob_cnt[p] == '1)); // R9
    end
endmodule

bind act_throttle_ctrl act_throttle_ctrl_chk #(
    .NUM_PAIRS(NUM_PAIRS),
    .CW       (LEVEL_W + 2),
    .GW       (GCNT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .win_end   (win_end),
    .glob_end  (glob_end),
    .act_req   (act_req),
    .act_grant (act_grant),
    .thr_active(thr_active),
    .win_cnt   (win_cnt),
    .glob_cnt  (glob_cnt)
);

// File: tb/act_throttle_ctrl_test.sv
`timescale 1ns/1ps
module act_throttle_ctrl_test;
    localparam int NP  = 2;
    localparam int WIN = 16;
    localparam int GN  = 20;
    localparam int GD  = 2;
    localparam int LW  = 8;
    localparam int GW  = 8;
    localparam int CW  = LW + 2;
    localparam int IW  = 2 * NP + NP * CW + NP * GW;

    logic                     clk = 1'b0;
    logic                     rst_n = 1'b0;
    logic [NP-1:0]            act_req = '0;
    logic [LW-1:0]            throttle_level = 8'd1;
    logic                     gwin_debug = 1'b0;
    logic [GW-1:0]            glob_thresh = 8'd40;
    logic [NP-1:0]            act_grant;
    logic [NP-1:0]            thr_active;
    logic [NP-1:0][CW-1:0]    win_cnt;
    logic [NP-1:0][GW-1:0]    glob_cnt;

    int checks = 0;
    int failures = 0;
    string cur_tag = "R1";

    logic [IW-1:0] exp_q[$];
    string         tag_q[$];

    // Bench model of the requirements.
    int m_wcyc, m_gwin, m_lvl, m_thr;
    bit m_dbg;
    bit m_en[NP];
    int m_wcnt[NP], m_gcnt[NP];

    always #2 clk = ~clk;

    act_throttle_ctrl #(
        .NUM_PAIRS(NP), .WIN_CLKS(WIN), .GLOBAL_NORMAL(GN),
        .GLOBAL_DEBUG(GD), .LEVEL_W(LW), .GCNT_W(GW)
    ) uut (
        .clk(clk), .rst_n(rst_n), .act_req(act_req),
        .throttle_level(throttle_level), .gwin_debug(gwin_debug),
        .glob_thresh(glob_thresh), .act_grant(act_grant),
        .thr_active(thr_active), .win_cnt(win_cnt), .glob_cnt(glob_cnt)
    );

    function automatic logic [IW-1:0] pack_dut();
        return {act_grant, thr_active, win_cnt, glob_cnt};
    endfunction

    function automatic bit m_grant(int p);
        return !(m_en[p] && m_lvl != 0 && m_wcnt[p] >= 4 * m_lvl);
    endfunction

    task automatic model_reset();
        m_wcyc = 0; m_gwin = 0; m_lvl = 0; m_thr = 255; m_dbg = 0;
        for (int p = 0; p < NP; p++) begin
            m_en[p] = 0; m_wcnt[p] = 0; m_gcnt[p] = 0;
        end
    endtask

    // Driver: called at a falling edge; predicts outputs, drives, advances model.
    task automatic step(input logic [NP-1:0] req);
        logic [NP-1:0]         eg, ea;
        logic [NP-1:0][CW-1:0] ew;
        logic [NP-1:0][GW-1:0] ec;
        bit we, ge;
        for (int p = 0; p < NP; p++) begin
            eg[p] = m_grant(p);
            ea[p] = m_en[p];
            ew[p] = CW'(m_wcnt[p]);
            ec[p] = GW'(m_gcnt[p]);
        end
        exp_q.push_back({eg, ea, ew, ec});
        tag_q.push_back(cur_tag);
        act_req = req;
        we = (m_wcyc == WIN - 1);
        ge = we && (m_gwin >= (m_dbg ? GD : GN) - 1);
        for (int p = 0; p < NP; p++) begin
            bit a;
            int tot;
            a   = req[p] && eg[p];
            tot = (a && m_gcnt[p] < 255) ? m_gcnt[p] + 1 : m_gcnt[p];
            if (ge) m_en[p] = (tot >= m_thr);
            if (we) m_wcnt[p] = 0;
            else if (a && m_wcnt[p] < 1023) m_wcnt[p] = m_wcnt[p] + 1;
            m_gcnt[p] = ge ? 0 : tot;
        end
        if (we) begin
            m_gwin = ge ? 0 : m_gwin + 1;
            m_lvl = throttle_level;
            m_thr = glob_thresh;
            m_dbg = gwin_debug;
        end
        m_wcyc = we ? 0 : m_wcyc + 1;
        @(negedge clk);
    endtask

    // Runs n cycles; pair bits in dense request every cycle, others every per-th cycle.
    task automatic run(input int n, input logic [NP-1:0] dense, input int per);
        for (int i = 0; i < n; i++) begin
            logic [NP-1:0] r;
            r = dense | (((i % per) == 0) ? ~dense : '0);
            step(r);
        end
    endtask

    // Monitor: pops each prediction and compares.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (exp_q.size() > 0) begin
                logic [IW-1:0] e, a;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                a = pack_dut();
                checks++;
                if (a !== e) begin
                    failures++;
                    $display("FAIL %s: outputs actual=%h expected=%h", t, a, e);
                end
            end
        end
    end

    task automatic check_direct(input string t, input logic [IW-1:0] a, input logic [IW-1:0] e);
        checks++;
        if (a !== e) begin
            failures++;
            $display("FAIL %s: actual=%h expected=%h", t, a, e);
        end
    endtask

    initial begin
        #(200000 * 4);
        failures++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        model_reset();
        // R1: reset state, with requests present.
        act_req = '1;
        repeat (3) @(negedge clk);
        check_direct("R1", pack_dut(), {2'b11, 2'b00, {(NP*CW){1'b0}}, {(NP*GW){1'b0}}});
        @(negedge clk);
        check_direct("R1", pack_dut(), {2'b11, 2'b00, {(NP*CW){1'b0}}, {(NP*GW){1'b0}}});
        act_req = '0;
        rst_n = 1'b1;

        // R10 / R5 / R9: pair0 busy all global window, pair1 sparse; pair0 saturates.
        cur_tag = "R10"; run(GN * WIN, 2'b01, 16);
        // R3: pair0 now throttled with budget 4 per window.
        cur_tag = "R3";  run(3 * WIN, 2'b01, 16);
        // R8: level raised mid-window, takes effect at the next boundary.
        cur_tag = "R8";  run(5, 2'b01, 16);
        throttle_level = 8'd2;
        run(2 * WIN, 2'b01, 16);
        // R2: level 0 keeps grants while flagged.
        cur_tag = "R2";  throttle_level = 8'd0;
        run(3 * WIN, 2'b01, 16);
        // R6: high threshold, moderate traffic, throttling drops off.
        cur_tag = "R6";  throttle_level = 8'd1; glob_thresh = 8'd250;
        run(GN * WIN, 2'b00, 4);
        // R7: debug mode gives short global windows; pair1 busy.
        cur_tag = "R7";  glob_thresh = 8'd20; gwin_debug = 1'b1;
        run(8 * WIN + 3, 2'b10, 32);
        // R4 / R9: both busy, back to normal mode.
        cur_tag = "R4";  gwin_debug = 1'b0; glob_thresh = 8'd255;
        run(GN * WIN + 2 * WIN, 2'b11, 1);
        cur_tag = "R9";  throttle_level = 8'd0;
        run(GN * WIN, 2'b11, 1);

        repeat (3) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule